// File: doc/BRIEF.md
# Pin Edge Capture and Interrupt Unit

This block watches a bank of general-purpose input pins and records level transitions on them. Each pin has a rising-edge enable and a falling-edge enable, which software programs through a small memory-mapped register port. When a pin shows a transition of an enabled kind, a sticky capture flag for that pin is raised. The flag stays up until software clears it by writing a one to its position in the capture register. Writing a zero leaves the flag as it is.

The capture flags drive the interrupt outputs. The low pins each own a private interrupt line. The remaining high pins share one line that is the OR of their flags. Pin inputs are asynchronous. Each pin passes through a multi-stage synchroniser before a transition is judged by comparing the synchronised level with the level one clock earlier.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the rising-enable, falling-enable and capture registers all read zero, and every interrupt output is low.
- R2: With only the rising enable set for a pin, a 0-to-1 transition on that pin sets its capture flag and a 1-to-0 transition does not.
- R3: With only the falling enable set for a pin, a 1-to-0 transition on that pin sets its capture flag and a 0-to-1 transition does not.
- R4: With both enables set for a pin, either kind of transition sets its capture flag.
- R5: A capture flag stays set after the pin returns to its earlier level, until software clears it.
- R6: A write to the capture register (byte offset 0x18) clears every flag whose write-data bit is one and leaves every flag whose write-data bit is zero unchanged.
- R7: If a pin's transition is detected in the same cycle that software writes a one to that pin's flag, the flag ends set.
- R8: For each pin n from 0 to 10, interrupt output bit n is high exactly while capture flag n is set. No other pin affects it.
- R9: The shared interrupt output is high exactly while at least one of capture flags 11 to 27 is set.
- R10: Register bits 31 to 28 always read zero, and writes to them have no effect.
- R11: The rising-enable register sits at byte offset 0x10 and the falling-enable register at 0x14. Both are read/write, and bit n controls pin n. Any address that maps to no register reads zero.
- R12: A capture flag and its interrupt become visible after the third rising clock edge that follows the pin change: two synchroniser stages, then the comparison register. They are not visible after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 28 | Asynchronous pin levels |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_direct | output | 11 | Private interrupt lines for pins 0 to 10 |
| irq_shared | output | 1 | Shared interrupt line for pins 11 to 27 |

## Verification
The bench times a transition against a clearing write so that both land on the same clock edge. A design that lets the clear win would lose that flag. It checks the flag one edge before and one edge after the expected latency, which exposes a synchroniser with a stage too few or too many. It sets and clears two shared-group flags one at a time, so a shared line built from only one flag, or from the wrong bit range, drops too early or never rises. It also writes zeros to the capture register and ones to the reserved bits, to catch a plain-write register or reserved bits that were wrongly stored.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;
   // register byte offsets inside the block
   localparam logic [7:0] RISE_EN_OFS = 8'h10;
   localparam logic [7:0] FALL_EN_OFS = 8'h14;
   localparam logic [7:0] CAPTURE_OFS = 8'h18;

   // default geometry
   localparam int unsigned DEF_PINS    = 28;
   localparam int unsigned DEF_DIRECT  = 11;
   localparam int unsigned DEF_STAGES  = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RISE = 2'd1,
      SEL_FALL = 2'd2,
      SEL_CAPT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/edge_finder.sv
module edge_finder #(
   parameter int unsigned WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] went_up;
   logic [WIDTH-1:0] went_down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   always_comb begin
      went_up   = level & ~prev_q;
      went_down = ~level & prev_q;
      hit       = (went_up & rise_en) | (went_down & fall_en);
   end
endmodule

// File: rtl/w1c_status.sv
module w1c_status #(
   parameter int unsigned WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_in,
   input  logic [WIDTH-1:0] clr_in,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] flags_q;

   // a new capture outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_in) | set_in;
   end

   assign flags = flags_q;
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned DIRECT = 11
) (
   input  logic [WIDTH-1:0]  flags,
   output logic [DIRECT-1:0] irq_direct,
   output logic              irq_shared
);
   genvar i;
   generate
      for (i = 0; i < DIRECT; i++) begin : g_direct
         assign irq_direct[i] = flags[i];
      end
      if (WIDTH > DIRECT) begin : g_group
         assign irq_shared = |flags[WIDTH-1:DIRECT];
      end else begin : g_no_group
         assign irq_shared = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
   import pin_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = DEF_PINS,
   parameter int unsigned NUM_DIRECT  = DEF_DIRECT,
   parameter int unsigned SYNC_STAGES = DEF_STAGES,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_in,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_DIRECT-1:0] irq_direct,
   output logic                  irq_shared
);
   localparam int unsigned RSV_W = DATA_W - NUM_PINS;

   generate
      if (NUM_PINS > DATA_W) begin : g_bad_width
         $error("pin_edge_irq: NUM_PINS exceeds DATA_W");
      end
      if (NUM_DIRECT == 0 || NUM_DIRECT > NUM_PINS) begin : g_bad_direct
         $error("pin_edge_irq: NUM_DIRECT out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pin_edge_irq: SYNC_STAGES below 2");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("pin_edge_irq: ADDR_W below 8");
      end
   endgenerate

   reg_sel_e              sel;
   logic [NUM_PINS-1:0]   rise_en_q;
   logic [NUM_PINS-1:0]   fall_en_q;
   logic [NUM_PINS-1:0]   pin_sync_lvl;
   logic [NUM_PINS-1:0]   edge_hit;
   logic [NUM_PINS-1:0]   clr_mask;
   logic [NUM_PINS-1:0]   sts_q;
   logic [NUM_PINS-1:0]   rd_field;

   always_comb begin
      sel = SEL_NONE;
      if (reg_addr == ADDR_W'(RISE_EN_OFS))      sel = SEL_RISE;
      else if (reg_addr == ADDR_W'(FALL_EN_OFS)) sel = SEL_FALL;
      else if (reg_addr == ADDR_W'(CAPTURE_OFS)) sel = SEL_CAPT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q <= '0;
         fall_en_q <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_RISE) rise_en_q <= reg_wdata[NUM_PINS-1:0];
         if (sel == SEL_FALL) fall_en_q <= reg_wdata[NUM_PINS-1:0];
      end
   end

   assign clr_mask = (reg_wr && sel == SEL_CAPT) ? reg_wdata[NUM_PINS-1:0] : '0;

   pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync_lvl)
   );

   edge_finder #(.WIDTH(NUM_PINS)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (pin_sync_lvl),
      .rise_en (rise_en_q),
      .fall_en (fall_en_q),
      .hit     (edge_hit)
   );

   w1c_status #(.WIDTH(NUM_PINS)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (edge_hit),
      .clr_in (clr_mask),
      .flags  (sts_q)
   );

   irq_fanout #(.WIDTH(NUM_PINS), .DIRECT(NUM_DIRECT)) u_irq (
      .flags      (sts_q),
      .irq_direct (irq_direct),
      .irq_shared (irq_shared)
   );

   always_comb begin
      unique case (sel)
         SEL_RISE: rd_field = rise_en_q;
         SEL_FALL: rd_field = fall_en_q;
         SEL_CAPT: rd_field = sts_q;
         default:  rd_field = '0;
      endcase
   end

   generate
      if (RSV_W > 0) begin : g_pad
         assign reg_rdata = {{RSV_W{1'b0}}, rd_field};
      end else begin : g_nopad
         assign reg_rdata = rd_field;
      end
   endgenerate
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
   parameter int unsigned NUM_PINS   = 28,
   parameter int unsigned NUM_DIRECT = 11,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic                  reg_wr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic [NUM_PINS-1:0]   sts,
   input logic [NUM_PINS-1:0]   hit,
   input logic [NUM_DIRECT-1:0] irq_direct,
   input logic                  irq_shared
);
   logic capt_wr;
   assign capt_wr = reg_wr && (reg_addr == ADDR_W'(pin_edge_pkg::CAPTURE_OFS));

   genvar i;
   generate
      for (i = 0; i < NUM_PINS; i++) begin : g_bit
         // R5
         sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[i] && !(capt_wr && reg_wdata[i])) |=> sts[i]);
         // R6
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (capt_wr && reg_wdata[i] && !hit[i]) |=> !sts[i]);
         // R7
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> sts[i]);
         // R2
         no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sts[i] |=> (!sts[i] || $past(hit[i])));
      end
   endgenerate

   // R8
   direct_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_direct == sts[NUM_DIRECT-1:0]);

   generate
      if (NUM_PINS > NUM_DIRECT) begin : g_shared
         // R9
         shared_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_shared == (sts[NUM_PINS-1:NUM_DIRECT] != '0));
      end
      if (DATA_W > NUM_PINS) begin : g_rsv
         // R10
         reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rdata[DATA_W-1:NUM_PINS] == '0);
      end
   endgenerate
endmodule

bind pin_edge_irq pin_edge_irq_chk #(
   .NUM_PINS   (NUM_PINS),
   .NUM_DIRECT (NUM_DIRECT),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .sts        (sts_q),
   .hit        (edge_hit),
   .irq_direct (irq_direct),
   .irq_shared (irq_shared)
);

// File: tb/test_pin_edge_irq.sv
module test_pin_edge_irq;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_RISE = 8'h10;
   localparam logic [7:0] A_FALL = 8'h14;
   localparam logic [7:0] A_CAPT = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] pin_in = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [10:0] irq_direct;
   logic        irq_shared;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_edge_irq i_pin_edge_irq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_direct(irq_direct), .irq_shared(irq_shared)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // change pins at a falling edge and wait out the full latency
   task automatic drive_pins(input logic [27:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_RISE, d); check("R1 rise reset", d, 0);
      rd(A_FALL, d); check("R1 fall reset", d, 0);
      rd(A_CAPT, d); check("R1 capture reset", d, 0);
      check("R1 irq reset", {20'd0, irq_shared, irq_direct}, 0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      wr(A_RISE, 32'hFFFF_FFFF);
      rd(A_RISE, d); check("R10 R11 rise map", d, 32'h0FFF_FFFF);
      wr(A_FALL, 32'hAAAA_AAAA);
      rd(A_FALL, d); check("R10 R11 fall map", d, 32'h0AAA_AAAA);
      rd(8'h04, d); check("R11 unmapped", d, 0);
      wr(A_RISE, 0); wr(A_FALL, 0);
      rd(A_RISE, d); check("R11 rise cleared", d, 0);
      wr(A_CAPT, 32'hF000_0000);
      rd(A_CAPT, d); check("R10 capture reserved", d, 0);
   endtask

   task automatic t_rise_latency();
      logic [31:0] d;
      wr(A_RISE, 32'h8);
      @(negedge clk);
      pin_in[3] = 1'b1;
      repeat (2) @(posedge clk);
      rd(A_CAPT, d); check("R12 not after 2 edges", d, 0);
      @(posedge clk);
      rd(A_CAPT, d); check("R12 R2 set after 3 edges", d, 32'h8);
      check("R8 direct pin3", {21'd0, irq_direct}, 32'h8);
      check("R9 shared idle", {31'd0, irq_shared}, 0);
      drive_pins(pin_in & ~28'h8);
      rd(A_CAPT, d); check("R5 sticky after return", d, 32'h8);
      wr(A_CAPT, 32'h8);
      rd(A_CAPT, d); check("R6 clear pin3", d, 0);
      drive_pins(pin_in | 28'h8);
      wr(A_CAPT, 32'h8);
      drive_pins(pin_in & ~28'h8);
      rd(A_CAPT, d); check("R2 falling ignored", d, 0);
      wr(A_RISE, 0);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(A_FALL, 32'h0010_0000);
      drive_pins(pin_in | 28'h010_0000);
      rd(A_CAPT, d); check("R3 rising ignored", d, 0);
      drive_pins(pin_in & ~28'h010_0000);
      rd(A_CAPT, d); check("R3 falling sets", d, 32'h0010_0000);
      check("R9 shared on pin20", {31'd0, irq_shared}, 1);
      check("R8 direct unaffected", {21'd0, irq_direct}, 0);
      wr(A_FALL, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(A_RISE, 32'h1);
      drive_pins(pin_in | 28'h1);
      wr(A_RISE, 0);
      wr(A_CAPT, 32'h0);
      rd(A_CAPT, d); check("R6 zero write keeps", d, 32'h0010_0001);
      wr(A_CAPT, 32'h1);
      rd(A_CAPT, d); check("R6 partial clear", d, 32'h0010_0000);
      check("R9 shared still set", {31'd0, irq_shared}, 1);
      wr(A_CAPT, 32'h0010_0000);
      rd(A_CAPT, d); check("R6 full clear", d, 0);
      check("R9 shared dropped", {31'd0, irq_shared}, 0);
      drive_pins(pin_in & ~28'h1);
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr(A_RISE, 32'h1); wr(A_FALL, 32'h1);
      drive_pins(pin_in | 28'h1);
      rd(A_CAPT, d); check("R4 rising sets", d, 32'h1);
      check("R8 direct pin0", {21'd0, irq_direct}, 32'h1);
      wr(A_CAPT, 32'h1);
      drive_pins(pin_in & ~28'h1);
      rd(A_CAPT, d); check("R4 falling sets", d, 32'h1);
      wr(A_CAPT, 32'h1);
      wr(A_RISE, 0); wr(A_FALL, 0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      wr(A_RISE, 32'h400);
      @(negedge clk);
      pin_in[10] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      reg_addr = A_CAPT; reg_wdata = 32'h400; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_CAPT, d); check("R7 set beats clear", d, 32'h400);
      check("R8 direct pin10", {21'd0, irq_direct}, 32'h400);
      wr(A_CAPT, 32'h400);
      wr(A_RISE, 0);
   endtask

   task automatic t_shared();
      logic [31:0] d;
      wr(A_RISE, 32'h0800_0800);
      drive_pins(pin_in | 28'h800_0800);
      rd(A_CAPT, d); check("R9 pins 11 and 27 set", d, 32'h0800_0800);
      check("R9 shared on", {31'd0, irq_shared}, 1);
      check("R8 no direct from group", {21'd0, irq_direct}, 0);
      wr(A_CAPT, 32'h800);
      check("R9 shared held by 27", {31'd0, irq_shared}, 1);
      wr(A_CAPT, 32'h0800_0000);
      check("R9 shared off", {31'd0, irq_shared}, 0);
      wr(A_RISE, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_rise_latency();
      t_fall();
      t_w1c();
      t_both();
      t_race();
      t_shared();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule